// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects peripheral status flags and their enable bits into a vector of pending interrupt numbers. It also latches software-interrupt, illegal-opcode and non-maskable requests. At each instruction boundary the CPU pulses an evaluate strobe. The block then names the single request to service, the address of its vector word, and which CPU mask bit to set on entry. It also reports the fixed service overhead in cycles.

Selection runs in fixed tiers. Software and illegal-opcode requests come first, in that order, and neither can be masked. Next comes the non-maskable request, which is gated by its own mask bit. Last come the ordinary sources, which are gated by the maskable-interrupt bit and scanned through a priority table that software can rewrite. A bootstrap-mode input moves the vector table base.

Several flags can feed one interrupt number. The block does not stack registers, read vectors or model peripherals; those are plain ports.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending vector is empty, so an evaluation reports no request, and the priority table holds identity order (entry k names number k).
- R2: On a cycle with `upd_i` high, source k becomes pending when its flag is 1 and, for a source with an enable, its enable is 1. Default mapping: sources 0 to 3 go to number 5, source 4 to 6, source 5 to 7, source 6 to 8, and source 7 (no enable) to 9. A flag with its enable at 0 raises nothing, and a flag at 0 withdraws the request.
- R3: Sources that share a number are merged. The number stays pending while any of its sources is active and is withdrawn only when all of them are inactive.
- R4: A software request (number 1) wins over everything, then an illegal-opcode request (number 2). Both are taken whatever the mask bits are, and each clears its own pending bit when taken.
- R5: A pending non-maskable request (number 3) is taken only when `nmi_mask_i` is 0, and taking it clears it. While it is pending with `nmi_mask_i` at 1, the evaluation services nothing, even if ordinary requests are pending.
- R6: With `irq_mask_i` at 1, no ordinary request is serviced.
- R7: Ordinary requests are picked as the first table entry, scanning upward from entry 0, whose number is pending. Taking one does not clear it, so it is reported again until its flag is withdrawn.
- R8: A write with `ord_we_i` stores `ord_val_i` into table entry `ord_idx_i`, and later scans use the new order.
- R9: `vec_addr_o` is the base plus twice the number. The base is 0xFFC0 with `boot_mode_i` at 0 and 0xBFC0 with it at 1.
- R10: A serviced non-maskable request raises `set_nmi_mask_o`, and any other serviced request raises `set_irq_mask_o`. `svc_cycles_o` is 14 when a request is serviced. With no request, both mask outputs and `svc_cycles_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag_i | input | 8 | Peripheral status flags |
| src_en_i | input | 8 | Peripheral enable bits |
| upd_i | input | 1 | Recompute peripheral pending bits this cycle |
| swi_req_i | input | 1 | Software-interrupt request pulse |
| ill_req_i | input | 1 | Illegal-opcode request pulse |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| irq_mask_i | input | 1 | CPU maskable-interrupt mask bit |
| nmi_mask_i | input | 1 | CPU non-maskable mask bit |
| boot_mode_i | input | 1 | Bootstrap mode, relocates the vector base |
| eval_i | input | 1 | Instruction-boundary evaluate strobe |
| ord_we_i | input | 1 | Priority table write enable |
| ord_idx_i | input | 5 | Priority table entry index |
| ord_val_i | input | 5 | Interrupt number to store |
| irq_valid_o | output | 1 | A request is serviced this evaluation |
| irq_num_o | output | 5 | Serviced interrupt number |
| vec_addr_o | output | 16 | Vector word address |
| set_irq_mask_o | output | 1 | CPU must set the maskable mask bit |
| set_nmi_mask_o | output | 1 | CPU must set the non-maskable mask bit |
| svc_cycles_o | output | 4 | Service overhead in cycles |

## Verification
The bench goes after the shared-number merge. It withdraws one of two active serial flags and then the other; a design that overwrote the bit per source instead of clearing before setting would drop the request early or keep it forever. It holds a non-maskable request under its mask while an ordinary request waits; a design that fell through to the ordinary tier would service number 6 where nothing is due. It also checks that software and illegal requests clear on take while ordinary ones repeat, that a rewritten table and bootstrap mode change the number and address, and that a second reset restores identity order.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [2:0] {
    TIER_NONE   = 3'd0,
    TIER_SWI    = 3'd1,
    TIER_ILL    = 3'd2,
    TIER_NMI    = 3'd3,
    TIER_PERIPH = 3'd4
  } tier_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NUM_INT = 20,
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC*$clog2(NUM_INT)-1:0] SRC_MAP = '0,
  parameter logic [NUM_SRC-1:0] SRC_HAS_EN = '0,
  parameter int SWI_ID = 1,
  parameter int ILL_ID = 2,
  parameter int NMI_ID = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_flag_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               upd_i,
  input  logic               swi_req_i,
  input  logic               ill_req_i,
  input  logic               nmi_req_i,
  input  logic               take_swi_i,
  input  logic               take_ill_i,
  input  logic               take_nmi_i,
  output logic [NUM_INT-1:0] pend_o
);
  localparam int IDW = $clog2(NUM_INT);

  logic [NUM_SRC-1:0] src_act;
  logic [NUM_INT-1:0] clr_vec, set_vec, per_mask;
  logic [NUM_INT-1:0] pend_q, pend_nxt;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    if (SRC_HAS_EN[k]) begin : g_en
      assign src_act[k] = src_flag_i[k] & src_en_i[k];
    end else begin : g_noen
      assign src_act[k] = src_flag_i[k];
    end
  end

  always_comb begin
    clr_vec  = '0;
    set_vec  = '0;
    per_mask = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      per_mask[SRC_MAP[k*IDW +: IDW]] = 1'b1;
      if (src_act[k]) set_vec[SRC_MAP[k*IDW +: IDW]] = 1'b1;
      else            clr_vec[SRC_MAP[k*IDW +: IDW]] = 1'b1;
    end
  end

  always_comb begin
    pend_nxt = pend_q;
    if (upd_i) pend_nxt = (pend_q & ~clr_vec) | set_vec;
    if (take_swi_i) pend_nxt[SWI_ID] = 1'b0;
    if (take_ill_i) pend_nxt[ILL_ID] = 1'b0;
    if (take_nmi_i) pend_nxt[NMI_ID] = 1'b0;
    if (swi_req_i)  pend_nxt[SWI_ID] = 1'b1;
    if (ill_req_i)  pend_nxt[ILL_ID] = 1'b1;
    if (nmi_req_i)  pend_nxt[NMI_ID] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

  assign pend_o = pend_q;

  AST_SWI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    take_swi_i && !swi_req_i |=> !pend_q[SWI_ID]); // R4
  AST_ILL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    take_ill_i && !ill_req_i |=> !pend_q[ILL_ID]); // R4
  AST_NMI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_i && !nmi_req_i |=> !pend_q[NMI_ID]); // R5
  AST_PERIPH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(pend_q & per_mask)); // R7
endmodule

// File: rtl/irq_order.sv
module irq_order #(
  parameter int NUM_INT = 20
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we_i,
  input  logic [$clog2(NUM_INT)-1:0]       idx_i,
  input  logic [$clog2(NUM_INT)-1:0]       val_i,
  output logic [NUM_INT*$clog2(NUM_INT)-1:0] order_o
);
  localparam int IDW = $clog2(NUM_INT);

  logic [IDW-1:0] ord_q   [NUM_INT];
  logic [IDW-1:0] ord_nxt [NUM_INT];

  always_comb begin
    for (int i = 0; i < NUM_INT; i++) ord_nxt[i] = ord_q[i];
    if (we_i && (int'(idx_i) < NUM_INT)) ord_nxt[idx_i] = val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_INT; i++) ord_q[i] <= IDW'(i);
    end else begin
      for (int i = 0; i < NUM_INT; i++) ord_q[i] <= ord_nxt[i];
    end
  end

  for (genvar i = 0; i < NUM_INT; i++) begin : g_out
    assign order_o[i*IDW +: IDW] = ord_q[i];
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_prio_pkg::*;
#(
  parameter int NUM_INT = 20,
  parameter int SWI_ID = 1,
  parameter int ILL_ID = 2,
  parameter int NMI_ID = 3
) (
  input  logic [NUM_INT-1:0]                 pend_i,
  input  logic [NUM_INT*$clog2(NUM_INT)-1:0] order_i,
  input  logic                               irq_mask_i,
  input  logic                               nmi_mask_i,
  output tier_e                              tier_o,
  output logic [$clog2(NUM_INT)-1:0]         num_o
);
  localparam int IDW = $clog2(NUM_INT);

  logic           found;
  logic [IDW-1:0] scan_num;
  logic [IDW-1:0] ent;

  always_comb begin
    found    = 1'b0;
    scan_num = '0;
    ent      = '0;
    for (int i = 0; i < NUM_INT; i++) begin
      ent = order_i[i*IDW +: IDW];
      if (!found && (int'(ent) < NUM_INT) && pend_i[ent]) begin
        found    = 1'b1;
        scan_num = ent;
      end
    end
  end

  always_comb begin
    tier_o = TIER_NONE;
    num_o  = '0;
    if (pend_i[SWI_ID]) begin
      tier_o = TIER_SWI;
      num_o  = IDW'(SWI_ID);
    end else if (pend_i[ILL_ID]) begin
      tier_o = TIER_ILL;
      num_o  = IDW'(ILL_ID);
    end else if (pend_i[NMI_ID]) begin
      if (!nmi_mask_i) begin
        tier_o = TIER_NMI;
        num_o  = IDW'(NMI_ID);
      end
    end else if (!irq_mask_i && found) begin
      tier_o = TIER_PERIPH;
      num_o  = scan_num;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_INT = 20,
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC*$clog2(NUM_INT)-1:0] SRC_MAP =
    {5'd9, 5'd8, 5'd7, 5'd6, 5'd5, 5'd5, 5'd5, 5'd5},
  parameter logic [NUM_SRC-1:0] SRC_HAS_EN = 8'b0111_1111,
  parameter int SWI_ID = 1,
  parameter int ILL_ID = 2,
  parameter int NMI_ID = 3,
  parameter logic [15:0] NORM_BASE = 16'hFFC0,
  parameter logic [15:0] BOOT_BASE = 16'hBFC0,
  parameter int SVC_CYCLES = 14
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SRC-1:0]                 src_flag_i,
  input  logic [NUM_SRC-1:0]                 src_en_i,
  input  logic                               upd_i,
  input  logic                               swi_req_i,
  input  logic                               ill_req_i,
  input  logic                               nmi_req_i,
  input  logic                               irq_mask_i,
  input  logic                               nmi_mask_i,
  input  logic                               boot_mode_i,
  input  logic                               eval_i,
  input  logic                               ord_we_i,
  input  logic [$clog2(NUM_INT)-1:0]         ord_idx_i,
  input  logic [$clog2(NUM_INT)-1:0]         ord_val_i,
  output logic                               irq_valid_o,
  output logic [$clog2(NUM_INT)-1:0]         irq_num_o,
  output logic [15:0]                        vec_addr_o,
  output logic                               set_irq_mask_o,
  output logic                               set_nmi_mask_o,
  output logic [$clog2(SVC_CYCLES+1)-1:0]    svc_cycles_o
);
  localparam int IDW = $clog2(NUM_INT);
  localparam int CYW = $clog2(SVC_CYCLES + 1);

  logic                   rst_sync_n;
  logic [NUM_INT-1:0]     pend;
  logic [NUM_INT*IDW-1:0] order;
  tier_e                  tier;
  logic [IDW-1:0]         num;
  logic                   serve;
  logic [15:0]            base;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_pend #(
    .NUM_INT(NUM_INT), .NUM_SRC(NUM_SRC), .SRC_MAP(SRC_MAP),
    .SRC_HAS_EN(SRC_HAS_EN), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .NMI_ID(NMI_ID)
  ) u_pend (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .src_flag_i (src_flag_i),
    .src_en_i   (src_en_i),
    .upd_i      (upd_i),
    .swi_req_i  (swi_req_i),
    .ill_req_i  (ill_req_i),
    .nmi_req_i  (nmi_req_i),
    .take_swi_i (eval_i && (tier == TIER_SWI)),
    .take_ill_i (eval_i && (tier == TIER_ILL)),
    .take_nmi_i (eval_i && (tier == TIER_NMI)),
    .pend_o     (pend)
  );

  irq_order #(.NUM_INT(NUM_INT)) u_order (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (ord_we_i),
    .idx_i   (ord_idx_i),
    .val_i   (ord_val_i),
    .order_o (order)
  );

  irq_pick #(
    .NUM_INT(NUM_INT), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .NMI_ID(NMI_ID)
  ) u_pick (
    .pend_i     (pend),
    .order_i    (order),
    .irq_mask_i (irq_mask_i),
    .nmi_mask_i (nmi_mask_i),
    .tier_o     (tier),
    .num_o      (num)
  );

  assign serve          = eval_i && (tier != TIER_NONE);
  assign base           = boot_mode_i ? BOOT_BASE : NORM_BASE;
  assign irq_valid_o    = serve;
  assign irq_num_o      = serve ? num : '0;
  assign vec_addr_o     = base + (16'(num) << 1);
  assign set_nmi_mask_o = serve && (tier == TIER_NMI);
  assign set_irq_mask_o = serve && (tier != TIER_NMI);
  assign svc_cycles_o   = serve ? CYW'(SVC_CYCLES) : '0;

  AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_valid_o && nmi_mask_i |-> irq_num_o != IDW'(NMI_ID)); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_valid_o && irq_mask_i |-> (irq_num_o == IDW'(SWI_ID)) ||
      (irq_num_o == IDW'(ILL_ID)) || (irq_num_o == IDW'(NMI_ID))); // R6
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_flag, src_en;
  logic       upd, swi, ill, nmi, imask, nmask, boot, eval_s, ord_we;
  logic [4:0] ord_idx, ord_val;
  logic       irq_valid, set_im, set_nm;
  logic [4:0] irq_num;
  logic [15:0] vec_addr;
  logic [3:0] svc_cyc;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic       valid;
    logic [4:0] num;
    logic       boot;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_flag_i(src_flag), .src_en_i(src_en),
    .upd_i(upd), .swi_req_i(swi), .ill_req_i(ill), .nmi_req_i(nmi),
    .irq_mask_i(imask), .nmi_mask_i(nmask), .boot_mode_i(boot),
    .eval_i(eval_s), .ord_we_i(ord_we), .ord_idx_i(ord_idx), .ord_val_i(ord_val),
    .irq_valid_o(irq_valid), .irq_num_o(irq_num), .vec_addr_o(vec_addr),
    .set_irq_mask_o(set_im), .set_nmi_mask_o(set_nm), .svc_cycles_o(svc_cyc)
  );

  task automatic step(input logic [7:0] fl, input logic [7:0] en,
                      input logic [2:0] rq, input logic mi, input logic mx,
                      input logic bt, input logic ev, input logic chk,
                      input logic ev_valid, input logic [4:0] ev_num,
                      input string tag);
    exp_t e;
    @(negedge clk);
    src_flag = fl; src_en = en; upd = 1'b1;
    swi = rq[0]; ill = rq[1]; nmi = rq[2];
    imask = mi; nmask = mx; boot = bt; eval_s = ev; ord_we = 1'b0;
    if (chk) begin
      e.valid = ev_valid; e.num = ev_num; e.boot = bt; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic ord_write(input logic [4:0] idx, input logic [4:0] val);
    @(negedge clk);
    swi = 1'b0; ill = 1'b0; nmi = 1'b0; eval_s = 1'b0;
    ord_we = 1'b1; ord_idx = idx; ord_val = val;
  endtask

  initial begin : monitor
    exp_t e;
    logic [15:0] ev_addr;
    forever begin
      @(negedge clk);
      #3;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (e.valid) begin
          ev_addr = (e.boot ? 16'hBFC0 : 16'hFFC0) + 16'(e.num) * 16'd2;
          if (!irq_valid || irq_num !== e.num || vec_addr !== ev_addr ||
              set_nm !== (e.num == 5'd3) || set_im !== (e.num != 5'd3) ||
              svc_cyc !== 4'd14) begin
            errors++;
            $display("FAIL %s: valid=%b num=%0d addr=%h si=%b sx=%b cyc=%0d expected valid=1 num=%0d addr=%h si=%b sx=%b cyc=14",
                     e.tag, irq_valid, irq_num, vec_addr, set_im, set_nm, svc_cyc,
                     e.num, ev_addr, e.num != 5'd3, e.num == 5'd3);
          end
        end else begin
          if (irq_valid !== 1'b0 || set_im !== 1'b0 || set_nm !== 1'b0 || svc_cyc !== 4'd0) begin
            errors++;
            $display("FAIL %s: valid=%b num=%0d si=%b sx=%b cyc=%0d expected valid=0 si=0 sx=0 cyc=0",
                     e.tag, irq_valid, irq_num, set_im, set_nm, svc_cyc);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    src_flag = '0; src_en = '0; upd = 0; swi = 0; ill = 0; nmi = 0;
    imask = 0; nmask = 0; boot = 0; eval_s = 0; ord_we = 0; ord_idx = '0; ord_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(8'h00, 8'h00, 3'b000, 0, 0, 0, 1, 1, 0, 0, "R1 empty after reset");
    step(8'h10, 8'h00, 3'b000, 0, 0, 0, 0, 0, 0, 0, "");
    step(8'h10, 8'h00, 3'b000, 0, 0, 0, 1, 1, 0, 0, "R2 enable off ignored");
    step(8'h10, 8'h10, 3'b000, 0, 0, 0, 0, 0, 0, 0, "");
    step(8'h10, 8'h10, 3'b000, 0, 0, 0, 1, 1, 1, 6, "R2 flag and enable");
    step(8'h10, 8'h10, 3'b000, 0, 0, 0, 1, 1, 1, 6, "R7 not cleared on take");
    step(8'h90, 8'h10, 3'b000, 0, 0, 0, 0, 0, 0, 0, "");
    step(8'h80, 8'h10, 3'b000, 0, 0, 0, 1, 1, 1, 6, "R7 identity order");
    step(8'h80, 8'h10, 3'b000, 0, 0, 0, 1, 1, 1, 9, "R2 source without enable");
    step(8'h00, 8'h10, 3'b000, 0, 0, 0, 0, 0, 0, 0, "");
    step(8'h00, 8'h10, 3'b000, 0, 0, 0, 1, 1, 0, 0, "R2 flag withdrawn");

    step(8'h05, 8'h0F, 3'b000, 0, 0, 0, 0, 0, 0, 0, "");
    step(8'h04, 8'h0F, 3'b000, 0, 0, 0, 1, 1, 1, 5, "R3 two shared flags");
    step(8'h00, 8'h0F, 3'b000, 0, 0, 0, 1, 1, 1, 5, "R3 one shared flag left");
    step(8'h00, 8'h0F, 3'b000, 0, 0, 0, 1, 1, 0, 0, "R3 all shared flags clear");

    step(8'h10, 8'h1F, 3'b000, 0, 0, 0, 0, 0, 0, 0, "");
    step(8'h10, 8'h1F, 3'b000, 1, 0, 0, 1, 1, 0, 0, "R6 maskable bit blocks");
    step(8'h10, 8'h1F, 3'b000, 0, 0, 0, 1, 1, 1, 6, "R6 unmasked");

    step(8'h10, 8'h1F, 3'b001, 0, 0, 0, 0, 0, 0, 0, "");
    step(8'h10, 8'h1F, 3'b000, 1, 1, 0, 1, 1, 1, 1, "R4 software unmaskable");
    step(8'h10, 8'h1F, 3'b000, 1, 1, 0, 1, 1, 0, 0, "R4 software cleared");
    step(8'h10, 8'h1F, 3'b011, 0, 0, 0, 0, 0, 0, 0, "");
    step(8'h10, 8'h1F, 3'b000, 1, 1, 0, 1, 1, 1, 1, "R4 software before illegal");
    step(8'h10, 8'h1F, 3'b000, 1, 1, 0, 1, 1, 1, 2, "R4 illegal next");
    step(8'h10, 8'h1F, 3'b000, 1, 1, 0, 1, 1, 0, 0, "R4 illegal cleared");

    step(8'h10, 8'h1F, 3'b100, 0, 0, 0, 0, 0, 0, 0, "");
    step(8'h10, 8'h1F, 3'b000, 0, 1, 0, 1, 1, 0, 0, "R5 masked nmi stalls all");
    step(8'h10, 8'h1F, 3'b000, 1, 0, 0, 1, 1, 1, 3, "R5 nmi taken R10 sets nmi mask");
    step(8'h10, 8'h1F, 3'b000, 0, 0, 0, 1, 1, 1, 6, "R5 nmi cleared");

    step(8'h30, 8'h3F, 3'b000, 0, 0, 0, 0, 0, 0, 0, "");
    step(8'h30, 8'h3F, 3'b000, 0, 0, 0, 1, 1, 1, 6, "R8 before rewrite");
    ord_write(5'd0, 5'd7);
    ord_write(5'd7, 5'd0);
    step(8'h30, 8'h3F, 3'b000, 0, 0, 0, 1, 1, 1, 7, "R8 rewritten order");
    step(8'h30, 8'h3F, 3'b000, 0, 0, 1, 1, 1, 1, 7, "R9 bootstrap base");
    step(8'h30, 8'h3F, 3'b000, 0, 0, 0, 1, 1, 1, 7, "R9 normal base");

    @(negedge clk);
    rst_n = 1'b0;
    step(8'h30, 8'h3F, 3'b000, 0, 0, 0, 1, 1, 0, 0, "R1 pending cleared by reset");
    step(8'h30, 8'h3F, 3'b000, 0, 0, 0, 0, 0, 0, 0, "");
    rst_n = 1'b1;
    repeat (4) step(8'h30, 8'h3F, 3'b000, 0, 0, 0, 0, 0, 0, 0, "");
    step(8'h30, 8'h3F, 3'b000, 0, 0, 0, 1, 1, 1, 6, "R1 identity order after reset");

    repeat (2) @(negedge clk);
    #5;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule